// File: doc/BRIEF.md
# Data Cache Write-Hit Policy Unit

This unit completes processor stores that are already known to hit in a data cache. Each store brings an address, an access size (byte, word or longword), right-aligned store data, a line index chosen by the tag logic, and a policy flag that marks the target region as write-through or copyback. The unit merges the store into the matching bytes of the selected word of the hit line, and it keeps one modified flag for each line.

The two policies differ in what leaves the unit. A copyback store changes only the cached copy: it marks the line modified and completes in the cycle it is presented. A write-through store updates the cached copy without touching the modified flag. It then places one transaction on a simple memory write port and holds the processor's ready low until that port accepts it. Stores with a bad alignment or size are refused with an error and leave no trace. The unit watches no other bus master, so coherency with DMA traffic is left to software. Tag lookup, miss handling, allocation and replacement live elsewhere. A combinational read port exposes any stored word and any line's modified flag to the load path.

Top module: `dcache_wrhit_unit`

## Requirements
- R1: Size encoding is 00 byte, 01 word (16 bits), 10 longword; data arrives right-aligned and is moved to the lanes picked by the two low address bits, lane n being data bits 8n+7..8n. A byte enables lane offset only, a word enables lanes offset and offset+1, and a longword enables all four lanes.
- R2: A write-through hit replaces exactly the enabled bytes of word address[3:2] of the hit line; all other bytes keep their values.
- R3: A write-through hit produces exactly one accepted transaction on the memory write port, carrying the address with bits 1..0 cleared, the lane-positioned data and the byte enables. These values stay stable while the port is not ready.
- R4: During a write-through hit, reqReady stays low until the cycle in which memWrReady is high while memWrValid is high. The store then completes in that cycle, and the line's modified flag keeps its earlier value.
- R5: A copyback hit updates the enabled bytes and sets the line's modified flag, whether or not it was already set. reqReady goes high in the cycle the store is presented, and no memory write is issued.
- R6: A word at an odd address, a longword whose address bits 1..0 are not 00, and size code 11 raise reqError together with reqReady in the presentation cycle. They change no line byte and no modified flag, and they issue no memory write.
- R7: A request with hitValid low is ignored: reqReady stays low, no memory write is issued and no state changes.
- R8: After reset every line word reads zero, every modified flag is clear, and memWrValid and reqReady are low.
- R9: rdData shows word rdWord of line rdLine, and rdModified shows that line's modified flag, both combinationally from the current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Store request present, held until reqReady |
| reqAddr | input | 32 | Store byte address |
| reqSize | input | 2 | Access size code |
| reqData | input | 32 | Right-aligned store data |
| reqCopyback | input | 1 | 1 copyback region, 0 write-through region |
| hitValid | input | 1 | Request hits in the cache |
| hitLine | input | 3 | Index of the hit line |
| reqReady | output | 1 | Store completes this cycle |
| reqError | output | 1 | Store refused for alignment or size |
| memWrValid | output | 1 | Memory write transaction pending |
| memWrReady | input | 1 | Memory accepts the pending write |
| memWrAddr | output | 32 | Word-aligned write address |
| memWrData | output | 32 | Lane-positioned write data |
| memWrByteEn | output | 4 | Byte-lane enables of the write |
| rdLine | input | 3 | Line index for the read port |
| rdWord | input | 2 | Word index for the read port |
| rdData | output | 32 | Selected stored word |
| rdModified | output | 1 | Modified flag of rdLine |

## Verification
The assertions assume that a processor holds reqValid, address, size, data, policy, hit and line index steady from the first cycle of a store until the cycle reqReady is high, and that memWrReady is only meaningful while memWrValid is high. The bench drives every store through one task that sets these inputs after a falling edge, keeps them fixed until it sees reqReady, and drops them at the next falling edge. It raises memWrReady only when it sees a pending write, after a chosen number of stall cycles.

// File: rtl/wrhit_pkg.sv
package wrhit_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_RSVD = 2'b11
  } accSize_e;

  // strobes from the controller into the datapath
  typedef struct packed {
    logic lineWr;   // merge lane data into the hit line
    logic setMod;   // mark hit line modified
    logic extLoad;  // capture the external write transaction
  } dpStrobe_t;

endpackage

// File: rtl/wrhit_lanes.sv
module wrhit_lanes
  import wrhit_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [OFF_W-1:0]  addrLow,
  input  logic [1:0]        sizeCode,
  input  logic [DATA_W-1:0] dataIn,
  output logic [LANES-1:0]  byteEn,
  output logic [DATA_W-1:0] laneData,
  output logic              misaligned
);

  accSize_e sizeSel;
  assign sizeSel = accSize_e'(sizeCode);

  // shift right-aligned data up to its byte lanes
  assign laneData = dataIn << {addrLow, 3'b000};

  always_comb begin
    byteEn     = '0;
    misaligned = 1'b0;
    unique case (sizeSel)
      SZ_BYTE: byteEn = LANES'(1) << addrLow;
      SZ_WORD: begin
        misaligned = addrLow[0];
        byteEn     = LANES'(3) << addrLow;
      end
      SZ_LONG: begin
        misaligned = (addrLow != '0);
        byteEn     = '1;
      end
      default: misaligned = 1'b1;
    endcase
    if (misaligned) byteEn = '0;
  end

  // R1: an accepted size never produces an empty lane set
  always_comb begin
    if (!misaligned) assert_lanes_nonempty_R1: assert (byteEn != '0);
  end

endmodule

// File: rtl/wrhit_ctl.sv
module wrhit_ctl
  import wrhit_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      hitValid,
  input  logic      reqCopyback,
  input  logic      misaligned,
  input  logic      memWrReady,
  output dpStrobe_t strobe,
  output logic      reqReady,
  output logic      reqError,
  output logic      memWrValid
);

  typedef enum logic {ST_IDLE = 1'b0, ST_EXT = 1'b1} ctlState_e;

  ctlState_e state, nextState;
  logic      takeReq;

  assign takeReq    = reqValid && hitValid && (state == ST_IDLE);
  assign memWrValid = (state == ST_EXT);

  always_comb begin
    nextState = state;
    strobe    = '0;
    reqReady  = 1'b0;
    reqError  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (takeReq) begin
          if (misaligned) begin
            reqReady = 1'b1;
            reqError = 1'b1;
          end else if (reqCopyback) begin
            strobe.lineWr = 1'b1;
            strobe.setMod = 1'b1;
            reqReady      = 1'b1;
          end else begin
            strobe.lineWr  = 1'b1;
            strobe.extLoad = 1'b1;
            nextState      = ST_EXT;
          end
        end
      end
      ST_EXT: begin
        if (memWrReady) begin
          reqReady  = 1'b1;
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  // R6: refused stores write nothing and complete with an error
  assert_err_nowrite_R6: assert property (@(posedge clk) disable iff (!rstN)
    takeReq && misaligned |-> reqError && reqReady && !strobe.lineWr && !strobe.extLoad);

  // R5: copyback completes at once and leaves no memory traffic behind
  assert_cb_no_ext_R5: assert property (@(posedge clk) disable iff (!rstN)
    takeReq && !misaligned && reqCopyback |-> reqReady ##1 !memWrValid);

  // R3: a write-through store always opens a memory transaction
  assert_wt_opens_ext_R3: assert property (@(posedge clk) disable iff (!rstN)
    takeReq && !misaligned && !reqCopyback |=> memWrValid);

  // R4: the processor is stalled while memory has not accepted
  assert_wt_stall_R4: assert property (@(posedge clk) disable iff (!rstN)
    memWrValid && !memWrReady |-> !reqReady);

  // R7: misses are not consumed here
  assert_miss_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    !memWrValid && !hitValid |-> !reqReady && !strobe.lineWr && !strobe.setMod);

endmodule

// File: rtl/wrhit_dp.sv
module wrhit_dp
  import wrhit_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int NUM_LINES = 8,
  parameter int LINE_WORDS = 4,
  localparam int LANES  = DATA_W / 8,
  localparam int OFF_W  = $clog2(LANES),
  localparam int LINE_W = $clog2(NUM_LINES),
  localparam int WSEL_W = $clog2(LINE_WORDS)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpStrobe_t               strobe,
  input  logic [LINE_W-1:0]       hitLine,
  input  logic [ADDR_W-OFF_W-1:0] wordAddr,
  input  logic [LANES-1:0]        byteEn,
  input  logic [DATA_W-1:0]       laneData,
  input  logic                    extPending,
  input  logic                    memWrReady,
  output logic [ADDR_W-1:0]       memWrAddr,
  output logic [DATA_W-1:0]       memWrData,
  output logic [LANES-1:0]        memWrByteEn,
  input  logic [LINE_W-1:0]       rdLine,
  input  logic [WSEL_W-1:0]       rdWord,
  output logic [DATA_W-1:0]       rdData,
  output logic                    rdModified
);

  logic [DATA_W-1:0]    lineMem [NUM_LINES][LINE_WORDS];
  logic [NUM_LINES-1:0] modified;
  logic [WSEL_W-1:0]    wordSel;

  assign wordSel = wordAddr[WSEL_W-1:0];

  // line storage with per-lane merge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int l = 0; l < NUM_LINES; l++)
        for (int w = 0; w < LINE_WORDS; w++)
          lineMem[l][w] <= '0;
    end else if (strobe.lineWr) begin
      for (int b = 0; b < LANES; b++)
        if (byteEn[b]) lineMem[hitLine][wordSel][8*b +: 8] <= laneData[8*b +: 8];
    end
  end

  // modified flags: only copyback sets them here
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              modified <= '0;
    else if (strobe.setMod) modified[hitLine] <= 1'b1;
  end

  // held external write transaction
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memWrAddr   <= '0;
      memWrData   <= '0;
      memWrByteEn <= '0;
    end else if (strobe.extLoad) begin
      memWrAddr   <= {wordAddr, {OFF_W{1'b0}}};
      memWrData   <= laneData;
      memWrByteEn <= byteEn;
    end
  end

  assign rdData     = lineMem[rdLine][rdWord];
  assign rdModified = modified[rdLine];

  // R5: after a copyback merge the line reads as modified
  assert_mod_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setMod |=> modified[$past(hitLine)]);

  // R4: a write-through merge leaves every modified flag alone
  assert_wt_mod_keep_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lineWr && !strobe.setMod |=> modified == $past(modified));

  // R3: the pending transaction does not move before acceptance
  assert_ext_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    extPending && !memWrReady && !strobe.extLoad |=>
      $stable(memWrAddr) && $stable(memWrData) && $stable(memWrByteEn));

  // R2: only lanes that are enabled can be merged
  assert_merge_lanes_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lineWr |-> byteEn != '0);

endmodule

// File: rtl/dcache_wrhit_unit.sv
module dcache_wrhit_unit
  import wrhit_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int NUM_LINES  = 8,
  parameter int LINE_WORDS = 4,
  localparam int LANES  = DATA_W / 8,
  localparam int OFF_W  = $clog2(LANES),
  localparam int LINE_W = $clog2(NUM_LINES),
  localparam int WSEL_W = $clog2(LINE_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [DATA_W-1:0] reqData,
  input  logic              reqCopyback,
  input  logic              hitValid,
  input  logic [LINE_W-1:0] hitLine,
  output logic              reqReady,
  output logic              reqError,
  output logic              memWrValid,
  input  logic              memWrReady,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic [LANES-1:0]  memWrByteEn,
  input  logic [LINE_W-1:0] rdLine,
  input  logic [WSEL_W-1:0] rdWord,
  output logic [DATA_W-1:0] rdData,
  output logic              rdModified
);

  dpStrobe_t          strobe;
  logic [LANES-1:0]   byteEn;
  logic [DATA_W-1:0]  laneData;
  logic               misaligned;

  wrhit_lanes #(.DATA_W(DATA_W)) uLanes (
    .addrLow   (reqAddr[OFF_W-1:0]),
    .sizeCode  (reqSize),
    .dataIn    (reqData),
    .byteEn    (byteEn),
    .laneData  (laneData),
    .misaligned(misaligned)
  );

  wrhit_ctl uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .hitValid   (hitValid),
    .reqCopyback(reqCopyback),
    .misaligned (misaligned),
    .memWrReady (memWrReady),
    .strobe     (strobe),
    .reqReady   (reqReady),
    .reqError   (reqError),
    .memWrValid (memWrValid)
  );

  wrhit_dp #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_LINES (NUM_LINES),
    .LINE_WORDS(LINE_WORDS)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .hitLine    (hitLine),
    .wordAddr   (reqAddr[ADDR_W-1:OFF_W]),
    .byteEn     (byteEn),
    .laneData   (laneData),
    .extPending (memWrValid),
    .memWrReady (memWrReady),
    .memWrAddr  (memWrAddr),
    .memWrData  (memWrData),
    .memWrByteEn(memWrByteEn),
    .rdLine     (rdLine),
    .rdWord     (rdWord),
    .rdData     (rdData),
    .rdModified (rdModified)
  );

endmodule

// File: tb/tb_dcache_wrhit_unit.sv
module tb_dcache_wrhit_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic [31:0] reqData = '0;
  logic        reqCopyback = 1'b0;
  logic        hitValid = 1'b0;
  logic [2:0]  hitLine = '0;
  logic        reqReady, reqError, memWrValid;
  logic        memWrReady = 1'b0;
  logic [31:0] memWrAddr, memWrData;
  logic [3:0]  memWrByteEn;
  logic [2:0]  rdLine = '0;
  logic [1:0]  rdWord = '0;
  logic [31:0] rdData;
  logic        rdModified;

  int checks = 0;
  int errors = 0;

  logic [31:0] modelMem [8][4];
  logic        modelMod [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  dcache_wrhit_unit dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqData(reqData), .reqCopyback(reqCopyback),
    .hitValid(hitValid), .hitLine(hitLine), .reqReady(reqReady),
    .reqError(reqError), .memWrValid(memWrValid), .memWrReady(memWrReady),
    .memWrAddr(memWrAddr), .memWrData(memWrData), .memWrByteEn(memWrByteEn),
    .rdLine(rdLine), .rdWord(rdWord), .rdData(rdData), .rdModified(rdModified)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // expected lanes from the size/offset rules
  task automatic expLanes(input logic [31:0] addr, input logic [1:0] size,
                          input logic [31:0] data, output logic [3:0] en,
                          output logic [31:0] ld, output logic bad);
    int off = int'(addr[1:0]);
    ld = data << (8*off);
    bad = 1'b0;
    en = 4'b0000;
    case (size)
      2'b00: en = 4'b0001 << off;
      2'b01: begin bad = addr[0]; en = 4'b0011 << off; end
      2'b10: begin bad = (addr[1:0] != 2'b00); en = 4'b1111; end
      default: bad = 1'b1;
    endcase
    if (bad) en = 4'b0000;
  endtask

  task automatic verifyWord(input string req, input int line, input int word);
    rdLine = 3'(line);
    rdWord = 2'(word);
    #1;
    chk(req, $sformatf("line%0d word%0d data", line, word), rdData, modelMem[line][word]);
    chk(req, $sformatf("line%0d modified", line), 32'(rdModified), 32'(modelMod[line]));
  endtask

  // one store from presentation to completion; called just after a falling edge
  task automatic doStore(input int line, input logic [31:0] addr, input logic [1:0] size,
                         input logic [31:0] data, input logic cb, input int waitCycles,
                         output int cyc, output logic err, output int hs,
                         output logic [31:0] exAddr, output logic [31:0] exData,
                         output logic [3:0] exEn, output logic extBad);
    logic [3:0]  en;
    logic [31:0] ld;
    logic        bad;
    int          waits = 0;
    logic        seen = 1'b0;
    cyc = 0; hs = 0; err = 1'b0; extBad = 1'b0;
    exAddr = '0; exData = '0; exEn = '0;
    reqAddr = addr; reqSize = size; reqData = data; reqCopyback = cb;
    hitLine = 3'(line); hitValid = 1'b1; reqValid = 1'b1;
    forever begin
      #1;
      if (memWrValid) begin
        if (!seen) begin
          exAddr = memWrAddr; exData = memWrData; exEn = memWrByteEn; seen = 1'b1;
        end else if (memWrAddr !== exAddr || memWrData !== exData || memWrByteEn !== exEn)
          extBad = 1'b1;
        memWrReady = (waits >= waitCycles);
        waits++;
        #1;
        if (!memWrReady && reqReady) extBad = 1'b1;
        if (memWrReady) hs++;
      end
      if (reqReady) begin
        err = reqError;
        @(posedge clk);
        break;
      end
      @(posedge clk);
      cyc++;
      if (cyc > 50) break;
      @(negedge clk);
    end
    @(negedge clk);
    reqValid = 1'b0; hitValid = 1'b0; memWrReady = 1'b0;
    expLanes(addr, size, data, en, ld, bad);
    if (!bad) begin
      for (int b = 0; b < 4; b++)
        if (en[b]) modelMem[line][addr[3:2]][8*b +: 8] = ld[8*b +: 8];
      if (cb) modelMod[line] = 1'b1;
    end
  endtask

  task automatic testReset();
    #1;
    chk("R8", "reqReady after reset", 32'(reqReady), 0);
    chk("R8", "memWrValid after reset", 32'(memWrValid), 0);
    for (int l = 0; l < 8; l++) verifyWord("R8", l, l % 4);
  endtask

  task automatic testWtByte();
    int cyc, hs; logic err, extBad; logic [31:0] a, d; logic [3:0] e;
    doStore(2, 32'h0000_1236, 2'b00, 32'h0000_00A5, 1'b0, 3, cyc, err, hs, a, d, e, extBad);
    chk("R4", "wt byte cycles to ready", 32'(cyc), 4);
    chk("R3", "wt byte accepted writes", 32'(hs), 1);
    chk("R3", "wt byte ext address", a, 32'h0000_1234);
    chk("R3", "wt byte ext data", d, 32'h00A5_0000);
    chk("R1", "wt byte lane enables", 32'(e), 32'b0100);
    chk("R3", "wt byte ext stable while stalled", 32'(extBad), 0);
    chk("R6", "wt byte no error", 32'(err), 0);
    verifyWord("R2", 2, 1);
  endtask

  task automatic testWtWordMerge();
    int cyc, hs; logic err, extBad; logic [31:0] a, d; logic [3:0] e;
    doStore(4, 32'h0000_0048, 2'b10, 32'hDEAD_BEEF, 1'b0, 0, cyc, err, hs, a, d, e, extBad);
    chk("R4", "wt long cycles to ready", 32'(cyc), 1);
    chk("R1", "long lane enables", 32'(e), 32'b1111);
    doStore(4, 32'h0000_004A, 2'b01, 32'h0000_1234, 1'b0, 1, cyc, err, hs, a, d, e, extBad);
    chk("R1", "upper word lane enables", 32'(e), 32'b1100);
    chk("R3", "upper word ext data", d, 32'h1234_0000);
    chk("R2", "merged word value", modelMem[4][2], 32'h1234_BEEF);
    verifyWord("R2", 4, 2);
    verifyWord("R4", 4, 0);
  endtask

  task automatic testCopyback();
    int cyc, hs; logic err, extBad; logic [31:0] a, d; logic [3:0] e;
    doStore(5, 32'h0000_005C, 2'b00, 32'h0000_0077, 1'b1, 0, cyc, err, hs, a, d, e, extBad);
    chk("R5", "cb cycles to ready", 32'(cyc), 0);
    chk("R5", "cb no memory write", 32'(hs), 0);
    verifyWord("R5", 5, 3);
    doStore(5, 32'h0000_005C, 2'b01, 32'h0000_ABCD, 1'b1, 0, cyc, err, hs, a, d, e, extBad);
    chk("R5", "cb on modified line no memory write", 32'(hs), 0);
    verifyWord("R5", 5, 3);
    doStore(5, 32'h0000_0050, 2'b00, 32'h0000_0011, 1'b0, 0, cyc, err, hs, a, d, e, extBad);
    chk("R4", "wt on modified line one write", 32'(hs), 1);
    chk("R1", "byte lane 0 enables", 32'(e), 32'b0001);
    verifyWord("R4", 5, 0);
  endtask

  task automatic testMisaligned();
    int cyc, hs; logic err, extBad; logic [31:0] a, d; logic [3:0] e;
    doStore(6, 32'h0000_0065, 2'b01, 32'h0000_FFFF, 1'b1, 0, cyc, err, hs, a, d, e, extBad);
    chk("R6", "odd word error", 32'(err), 1);
    chk("R6", "odd word cycles", 32'(cyc), 0);
    doStore(6, 32'h0000_0066, 2'b10, 32'hFFFF_FFFF, 1'b0, 0, cyc, err, hs, a, d, e, extBad);
    chk("R6", "unaligned long error", 32'(err), 1);
    chk("R6", "unaligned long no memory write", 32'(hs), 0);
    doStore(6, 32'h0000_0064, 2'b11, 32'hFFFF_FFFF, 1'b1, 0, cyc, err, hs, a, d, e, extBad);
    chk("R6", "size 11 error", 32'(err), 1);
    verifyWord("R6", 6, 1);
  endtask

  task automatic testMiss();
    logic sawReady = 1'b0, sawExt = 1'b0;
    reqAddr = 32'h0000_0070; reqSize = 2'b10; reqData = 32'h5555_5555;
    reqCopyback = 1'b1; hitLine = 3'd7; hitValid = 1'b0; reqValid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #1;
      if (reqReady) sawReady = 1'b1;
      if (memWrValid) sawExt = 1'b1;
      @(posedge clk);
      @(negedge clk);
    end
    reqValid = 1'b0;
    chk("R7", "miss reqReady", 32'(sawReady), 0);
    chk("R7", "miss memWrValid", 32'(sawExt), 0);
    verifyWord("R7", 7, 0);
  endtask

  task automatic testReadPort();
    for (int l = 0; l < 8; l++) verifyWord("R9", l, 0);
    verifyWord("R9", 5, 3);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int l = 0; l < 8; l++) begin
      modelMod[l] = 1'b0;
      for (int w = 0; w < 4; w++) modelMem[l][w] = '0;
    end
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testWtByte();
    testWtWordMerge();
    testCopyback();
    testMisaligned();
    testMiss();
    testReadPort();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule